// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating dual-slope converter. An external integrator, reference source and zero-crossing comparator do the analog work. The block decides which of three analog switches is closed, times each phase, and counts clocks to produce a binary result.

When a start request arrives while the block is idle, it runs three phases. First it shorts the integrator for a programmable number of clocks so that no charge is left over from the previous measurement. Next it connects the unknown input for a fixed window of exactly 2^N clocks. Last it connects the reference of opposite polarity and counts clocks until the comparator reports that the integrator has returned to zero. The count is latched as the result, a one-cycle done pulse is raised, and the block goes back to idle with all switches open.

The comparator output reaches the counting logic through a two-flop synchronizer, and the result includes that fixed latency. If the comparator has not flipped within 2^N de-integrate clocks, the block stops, reports all ones and flags an overrange.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and after its release, all three switch outputs, busy, done and overrange are low and the result is zero.
- R2: A start request sampled high while idle raises busy at the next edge and closes only the zero switch for exactly AZ_CYCLES clocks.
- R3: Right after the auto-zero phase, the input switch is closed alone for exactly 2^RES_W clocks.
- R4: After the run-up window the reference switch closes. Count the rising edges after the one that closed it, starting at 1. If k is the first such edge at which cmp_i is sampled low (low means the zero crossing has been reached) and k+1 is at most 2^RES_W-1, then the result is k+1 and the reference switch stays closed for k+2 clocks.
- R5: done_o is high for one cycle only. It is high in the cycle in which the new result first appears, and in that cycle busy and all switches are already low.
- R6: If cmp_i is still high at edge 2^RES_W-1 of the de-integrate phase, the reference switch opens after 2^RES_W clocks, the result is all ones and overrange_o is high.
- R7: The result and overrange_o change only together with a done pulse, so an in-range conversion that follows an overrange clears the flag.
- R8: A start request that arrives while busy is high changes neither the phase lengths nor the result, and it produces no extra done pulse.
- R9: At most one of the three switch outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a conversion. It is acted on only when the block is idle |
| cmp_i | input | 1 | Comparator output, asynchronous. 1 means the integrator is still on the nonzero side |
| sw_input_o | output | 1 | Connects the unknown input to the integrator |
| sw_ref_o | output | 1 | Connects the opposite-polarity reference to the integrator |
| sw_zero_o | output | 1 | Shorts the integrator (auto-zero) |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse when the result updates |
| overrange_o | output | 1 | The last conversion saturated |
| result_o | output | RES_W | Last conversion count |

## Verification
The assertions assume that cmp_i may be high during auto-zero and run-up. They assume it falls only once the integrator has been driven back toward zero, and that start_i is a plain level sampled on clock edges. The bench keeps cmp_i high from each start until a chosen de-integrate edge and then drops it. It only moves start_i and cmp_i on falling clock edges. Start pulses during busy are timed to land inside the run-up window.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AZERO = 2'd1,
    PH_RUNUP = 2'd2,
    PH_DEINT = 2'd3
  } phase_e;
endpackage

// File: rtl/dsadc_sync2.sv
module dsadc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/dsadc_phase_cnt.sv
module dsadc_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || en_i)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RES_W-1:0] val_i,
  input  logic             ovr_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic [RES_W-1:0] res_q;
  logic             ovr_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (load_i) begin
      res_q <= val_i;
      ovr_q <= ovr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= load_i;
  end

  assign result_o = res_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int AZ_CYCLES = 1 << RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sw_input_o,
  output logic             sw_ref_o,
  output logic             sw_zero_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrange_o,
  output logic [RES_W-1:0] result_o
);
  localparam int AZ_W = (AZ_CYCLES > 1) ? $clog2(AZ_CYCLES) : 1;
  localparam int CW   = (AZ_W > RES_W) ? AZ_W : RES_W;
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_CYCLES - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'((1 << RES_W) - 1);

  phase_e           state_q, state_d;
  logic [CW-1:0]    cnt;
  logic             cnt_clr, cnt_en;
  logic             cmp_sync;
  logic             res_load, res_ovr;
  logic [RES_W-1:0] res_val;

  dsadc_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_i),
    .sync_o  (cmp_sync)
  );

  dsadc_phase_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  // next-state and phase control
  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    cnt_en   = 1'b0;
    res_load = 1'b0;
    res_ovr  = 1'b0;
    res_val  = cnt[RES_W-1:0];
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d = PH_AZERO;
          cnt_clr = 1'b1;
        end
      end
      PH_AZERO: begin
        if (cnt == AZ_LAST) begin
          state_d = PH_RUNUP;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_RUNUP: begin
        if (cnt == WIN_LAST) begin
          state_d = PH_DEINT;
          cnt_clr = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      PH_DEINT: begin
        if (!cmp_sync) begin
          state_d  = PH_IDLE;
          res_load = 1'b1;
        end else if (cnt == WIN_LAST) begin
          state_d  = PH_IDLE;
          res_load = 1'b1;
          res_ovr  = 1'b1;
          res_val  = '1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  dsadc_result_reg #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (res_load),
    .val_i    (res_val),
    .ovr_i    (res_ovr),
    .result_o (result_o),
    .ovr_o    (overrange_o),
    .done_o   (done_o)
  );

  assign sw_zero_o  = (state_q == PH_AZERO);
  assign sw_input_o = (state_q == PH_RUNUP);
  assign sw_ref_o   = (state_q == PH_DEINT);
  assign busy_o     = (state_q != PH_IDLE);
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_input_o,
  input logic             sw_ref_o,
  input logic             sw_zero_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             overrange_o,
  input logic [RES_W-1:0] result_o
);
  localparam logic [RES_W:0] WIN = (RES_W+1)'(1 << RES_W);

  logic [RES_W:0] ru_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ru_len <= '0;
    else if (sw_input_o) ru_len <= ru_len + 1'b1;
    else                 ru_len <= '0;
  end

  assert_one_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_input_o, sw_ref_o, sw_zero_o}));

  assert_zero_before_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_input_o) |-> $past(sw_zero_o));

  assert_runup_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_input_o) |-> (ru_len == WIN));

  assert_ref_after_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ref_o) |-> $past(sw_input_o));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !sw_ref_o && !sw_input_o && !sw_zero_o));

  assert_ovr_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrange_o |-> (&result_o));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(overrange_o)));
endmodule

bind dsadc_seq dsadc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_input_o  (sw_input_o),
  .sw_ref_o    (sw_ref_o),
  .sw_zero_o   (sw_zero_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .overrange_o (overrange_o),
  .result_o    (result_o)
);

// File: tb/tb_dsadc_seq.sv
module tb_dsadc_seq;
  localparam int CLK_NS = 10;
  localparam int N      = 8;
  localparam int WIN    = 1 << N;
  localparam int MAXV   = WIN - 1;
  localparam int AZ     = WIN;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         cmp_i = 1'b1;
  logic         sw_input_o, sw_ref_o, sw_zero_o, busy_o, done_o, overrange_o;
  logic [N-1:0] result_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  dsadc_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sw_input_o(sw_input_o), .sw_ref_o(sw_ref_o), .sw_zero_o(sw_zero_o),
    .busy_o(busy_o), .done_o(done_o), .overrange_o(overrange_o),
    .result_o(result_o)
  );

  function automatic int exp_result(input int k);
    return (k + 1 <= MAXV) ? k + 1 : MAXV;
  endfunction

  function automatic int exp_ovr(input int k);
    return (k + 1 > MAXV) ? 1 : 0;
  endfunction

  function automatic int exp_deint_len(input int k);
    return (k + 1 <= MAXV) ? k + 2 : WIN;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic convert(input int k, input bit inject);
    int az_n = 0, ru_n = 0, de_n = 0, multi = 0, guard = 0;
    int got_res = -1, got_ovr = -1;
    bit seen = 0;
    cmp_i = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o === 1'b1 && sw_zero_o === 1'b1, "R2 busy+zero after start", busy_o, 1);
    while (!seen && guard < 5000) begin
      guard++;
      if (sw_zero_o)  az_n++;
      if (sw_input_o) ru_n++;
      if (sw_ref_o) begin
        de_n++;
        if (de_n == k) cmp_i = 1'b0;
      end
      if ((32'(sw_zero_o) + 32'(sw_input_o) + 32'(sw_ref_o)) > 1) multi++;
      start_i = (inject && sw_input_o && ru_n == 5) ? 1'b1 : 1'b0;
      if (done_o) begin
        seen = 1;
        got_res = int'(result_o);
        got_ovr = int'(overrange_o);
        check(busy_o === 1'b0 && !sw_ref_o && !sw_input_o && !sw_zero_o,
              "R5 idle at done", busy_o, 0);
      end else begin
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    check(seen, "R5 done seen", seen, 1);
    check(az_n == AZ, "R2 auto-zero length", az_n, AZ);
    check(ru_n == WIN, inject ? "R8 run-up length with start" : "R3 run-up length", ru_n, WIN);
    check(de_n == exp_deint_len(k), exp_ovr(k) ? "R6 de-int length" : "R4 de-int length",
          de_n, exp_deint_len(k));
    check(got_res == exp_result(k), exp_ovr(k) ? "R6 result" : "R4 result",
          got_res, exp_result(k));
    check(got_ovr == exp_ovr(k), "R7 overrange flag", got_ovr, exp_ovr(k));
    check(multi == 0, "R9 one switch", multi, 0);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R5 single pulse", done_o, 0);
    check(int'(result_o) == exp_result(k), "R7 result held", int'(result_o), exp_result(k));
    if (inject) begin
      repeat (3) @(negedge clk);
      check(busy_o === 1'b0, "R8 no extra conversion", busy_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4113));
    repeat (3) @(negedge clk);
    check(!sw_input_o && !sw_ref_o && !sw_zero_o && !busy_o && !done_o && !overrange_o
          && result_o == '0, "R1 in reset", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sw_input_o && !sw_ref_o && !sw_zero_o && !busy_o && !done_o && !overrange_o
          && result_o == '0, "R1 after reset", int'(busy_o), 0);

    convert(1, 0);          // R4 smallest crossing
    convert(MAXV - 1, 0);   // R4 largest in-range
    convert(MAXV, 0);       // R6 first overrange
    convert(100, 0);        // R7 flag clears
    convert(100000, 0);     // R6 never crosses
    convert(37, 1);         // R8 start while busy
    for (int i = 0; i < 10; i++) begin
      convert(int'($urandom_range(MAXV - 1, 1)), ($urandom_range(3, 0) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule